// File: doc/BRIEF.md
# Exception Entry Sequencer

This block handles the first step of taking an interrupt request (IRQ) or a software interrupt (SWI) in a processor that can run either a 16-bit compact instruction set or a 32-bit wide one. Each cycle it looks at the two request inputs, the current status word and the pipelined program counter. When it accepts an exception, it produces everything the core needs to switch context: the privilege mode the banked register file must change to, the value to write into the link register, the new program counter, the copy of the old status word for the saved-status register, and the new status word. It also pulses a pipeline flush.

Each accepted request gives exactly one entry cycle. All outputs are registered. The write strobe and the flush rise on the clock edge after the request is sampled and fall on the next edge. While the flush is high the sequencer takes no new request, because the status word it would read has not yet been updated by the core. The vector bases, the bit positions of the state flag and the IRQ-disable flag, the instruction widths and the order of SWI and IRQ when both arrive together are all parameters.

Top module: `eex_seq`

## Requirements
- R1: While reset is low, and after it is released with no request, `entry_we` and `pipe_flush` are 0 and `mode_tgt`, `lr_wdata`, `pc_wdata`, `saved_wdata` and `stat_wdata` are all zero.
- R2: An IRQ request is not taken when status bit 7 (IRQ disable) is 1. In that case neither strobe rises, and all data outputs keep their previous values.
- R3: A software-interrupt request is always taken, whatever the value of status bit 7, unless the block is in its flush cycle.
- R4: An accepted request, sampled on clock edge k, drives `entry_we` and `pipe_flush` to 1 from edge k to edge k+1 only.
- R5: The target mode is 0x12 for an IRQ and 0x13 for a software interrupt. It appears on `mode_tgt` and in bits [4:0] of `stat_wdata`.
- R6: For an IRQ, `lr_wdata` = pc_in − w + 4. Here w is 2 when status bit 5 (compact state) is 1 and 4 when it is 0. The subtraction wraps modulo 2^32.
- R7: For a software interrupt, `lr_wdata` = pc_in − w, with w as in R6, wrapping modulo 2^32.
- R8: `pc_wdata` is the vector base plus a prefetch offset of 4. With the default bases this gives 0x1C for an IRQ (base 0x18) and 0x0C for a software interrupt (base 0x08).
- R9: `saved_wdata` equals the status word that was sampled with the accepted request.
- R10: `stat_wdata` equals the sampled status word with three changes: bit 5 is cleared, bit 7 is set and bits [4:0] hold the target mode. All other bits are unchanged.
- R11: With the default priority, when both requests are present in the same cycle, the software interrupt is taken and the IRQ is not.
- R12: Any request present in the cycle where `pipe_flush` is 1 is ignored. A request still held after that cycle is taken on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| swi_req | input | 1 | Software-interrupt strobe |
| stat_in | input | XLEN | Current status word (mode in [4:0], compact-state bit 5, IRQ-disable bit 7) |
| pc_in | input | XLEN | Current pipelined program counter |
| entry_we | output | 1 | One-cycle write strobe for mode, LR, PC and both status words |
| mode_tgt | output | 5 | Mode the banked register file must switch to |
| lr_wdata | output | XLEN | Link register write value |
| pc_wdata | output | XLEN | New program counter |
| saved_wdata | output | XLEN | Value for the new mode's saved-status register |
| stat_wdata | output | XLEN | Updated status word |
| pipe_flush | output | 1 | One-cycle pipeline flush |

## Verification
The assertions assume that `stat_in` and `pc_in` are stable around each clock edge. They also assume that the core updates the status word only after an entry, so the flush cycle is the only cycle in which requests may be refused for reasons other than masking. The stimulus changes inputs only on the falling edge and removes each request right after the edge that accepts it. It holds a request through a flush cycle only in the dedicated lockout check. The sweep covers every combination of request kind, state bit and disable bit, together with program counters near zero and near the top of the address space, so that the wrap of the link value is exercised.

// File: rtl/eex_pkg.sv
package eex_pkg;
   typedef enum logic [1:0] {
      EK_NONE = 2'd0,
      EK_IRQ  = 2'd1,
      EK_SWI  = 2'd2
   } exc_kind_e;

   localparam int          MODE_W      = 5;
   localparam logic [4:0]  MODE_IRQ_C  = 5'h12;
   localparam logic [4:0]  MODE_SVC_C  = 5'h13;
endpackage

// File: rtl/eex_arb.sv
module eex_arb #(
   parameter bit SWI_WINS = 1'b1
) (
   input  logic                irq_req,
   input  logic                swi_req,
   input  logic                irq_dis,
   input  logic                busy,
   output eex_pkg::exc_kind_e  kind
);
   import eex_pkg::*;

   logic irq_ok;
   logic swi_ok;

   assign irq_ok = irq_req & ~irq_dis & ~busy;
   assign swi_ok = swi_req & ~busy;

   generate
      if (SWI_WINS) begin : g_swi_first
         always_comb begin
            if (swi_ok)      kind = EK_SWI;
            else if (irq_ok) kind = EK_IRQ;
            else             kind = EK_NONE;
         end
      end else begin : g_irq_first
         always_comb begin
            if (irq_ok)      kind = EK_IRQ;
            else if (swi_ok) kind = EK_SWI;
            else             kind = EK_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/eex_calc.sv
module eex_calc #(
   parameter int          XLEN          = 32,
   parameter int          STATE_BIT     = 5,
   parameter int          IDIS_BIT      = 7,
   parameter int          WIDE_BYTES    = 4,
   parameter int          COMPACT_BYTES = 2,
   parameter int          PREFETCH      = 4,
   parameter logic [31:0] IRQ_VEC       = 32'h18,
   parameter logic [31:0] SWI_VEC       = 32'h08
) (
   input  eex_pkg::exc_kind_e          kind,
   input  logic [XLEN-1:0]             stat,
   input  logic [XLEN-1:0]             pc,
   output logic [eex_pkg::MODE_W-1:0]  mode,
   output logic [XLEN-1:0]             lr_val,
   output logic [XLEN-1:0]             pc_val,
   output logic [XLEN-1:0]             stat_new
);
   import eex_pkg::*;

   localparam logic [XLEN-1:0] W_WIDE   = XLEN'(WIDE_BYTES);
   localparam logic [XLEN-1:0] W_CMPCT  = XLEN'(COMPACT_BYTES);
   localparam logic [XLEN-1:0] PF_OFS   = XLEN'(PREFETCH);
   localparam logic [XLEN-1:0] IRQ_DEST = XLEN'(IRQ_VEC) + PF_OFS;
   localparam logic [XLEN-1:0] SWI_DEST = XLEN'(SWI_VEC) + PF_OFS;

   logic [XLEN-1:0] ins_w;
   logic [XLEN-1:0] back;
   logic            is_swi;

   assign is_swi = (kind == EK_SWI);
   assign ins_w  = stat[STATE_BIT] ? W_CMPCT : W_WIDE;
   assign back   = pc - ins_w;

   always_comb begin
      mode   = is_swi ? MODE_SVC_C : MODE_IRQ_C;
      lr_val = is_swi ? back : back + PF_OFS;
      pc_val = is_swi ? SWI_DEST : IRQ_DEST;
      stat_new                = stat;
      stat_new[MODE_W-1:0]    = mode;
      stat_new[STATE_BIT]     = 1'b0;
      stat_new[IDIS_BIT]      = 1'b1;
   end
endmodule

// File: rtl/eex_seq.sv
module eex_seq #(
   parameter int          XLEN          = 32,
   parameter int          STATE_BIT     = 5,
   parameter int          IDIS_BIT      = 7,
   parameter int          WIDE_BYTES    = 4,
   parameter int          COMPACT_BYTES = 2,
   parameter int          PREFETCH      = 4,
   parameter logic [31:0] IRQ_VEC       = 32'h18,
   parameter logic [31:0] SWI_VEC       = 32'h08,
   parameter bit          SWI_WINS      = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic            swi_req,
   input  logic [XLEN-1:0] stat_in,
   input  logic [XLEN-1:0] pc_in,
   output logic            entry_we,
   output logic [4:0]      mode_tgt,
   output logic [XLEN-1:0] lr_wdata,
   output logic [XLEN-1:0] pc_wdata,
   output logic [XLEN-1:0] saved_wdata,
   output logic [XLEN-1:0] stat_wdata,
   output logic            pipe_flush
);
   import eex_pkg::*;

   generate
      if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
         $error("eex_seq: XLEN out of supported range");
      end
      if (STATE_BIT < MODE_W || STATE_BIT >= XLEN) begin : g_bad_state
         $error("eex_seq: STATE_BIT must lie above the mode field");
      end
      if (IDIS_BIT < MODE_W || IDIS_BIT >= XLEN || IDIS_BIT == STATE_BIT) begin : g_bad_idis
         $error("eex_seq: IDIS_BIT misplaced");
      end
      if (COMPACT_BYTES <= 0 || WIDE_BYTES <= COMPACT_BYTES) begin : g_bad_width
         $error("eex_seq: instruction widths inconsistent");
      end
   endgenerate

   exc_kind_e          kind;
   logic [MODE_W-1:0]  mode_c;
   logic [XLEN-1:0]    lr_c;
   logic [XLEN-1:0]    pc_c;
   logic [XLEN-1:0]    stat_c;
   logic               take;

   eex_arb #(.SWI_WINS(SWI_WINS)) u_arb (
      .irq_req (irq_req),
      .swi_req (swi_req),
      .irq_dis (stat_in[IDIS_BIT]),
      .busy    (pipe_flush),
      .kind    (kind)
   );

   eex_calc #(
      .XLEN(XLEN), .STATE_BIT(STATE_BIT), .IDIS_BIT(IDIS_BIT),
      .WIDE_BYTES(WIDE_BYTES), .COMPACT_BYTES(COMPACT_BYTES),
      .PREFETCH(PREFETCH), .IRQ_VEC(IRQ_VEC), .SWI_VEC(SWI_VEC)
   ) u_calc (
      .kind     (kind),
      .stat     (stat_in),
      .pc       (pc_in),
      .mode     (mode_c),
      .lr_val   (lr_c),
      .pc_val   (pc_c),
      .stat_new (stat_c)
   );

   assign take = (kind != EK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_we   <= 1'b0;
         pipe_flush <= 1'b0;
      end else begin
         entry_we   <= take;
         pipe_flush <= take;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_tgt    <= '0;
         lr_wdata    <= '0;
         pc_wdata    <= '0;
         saved_wdata <= '0;
         stat_wdata  <= '0;
      end else if (take) begin
         mode_tgt    <= mode_c;
         lr_wdata    <= lr_c;
         pc_wdata    <= pc_c;
         saved_wdata <= stat_in;
         stat_wdata  <= stat_c;
      end
   end
endmodule

// File: rtl/eex_seq_chk.sv
module eex_seq_chk #(
   parameter int          XLEN          = 32,
   parameter int          STATE_BIT     = 5,
   parameter int          IDIS_BIT      = 7,
   parameter int          WIDE_BYTES    = 4,
   parameter int          COMPACT_BYTES = 2,
   parameter int          PREFETCH      = 4,
   parameter logic [31:0] IRQ_VEC       = 32'h18,
   parameter logic [31:0] SWI_VEC       = 32'h08,
   parameter bit          SWI_WINS      = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            swi_req,
   input logic [XLEN-1:0] stat_in,
   input logic [XLEN-1:0] pc_in,
   input logic            entry_we,
   input logic [4:0]      mode_tgt,
   input logic [XLEN-1:0] lr_wdata,
   input logic [XLEN-1:0] pc_wdata,
   input logic [XLEN-1:0] saved_wdata,
   input logic [XLEN-1:0] stat_wdata,
   input logic            pipe_flush
);
   localparam logic [4:0]      SVC   = 5'h13;
   localparam logic [4:0]      IRQM  = 5'h12;
   localparam logic [XLEN-1:0] WW    = XLEN'(WIDE_BYTES);
   localparam logic [XLEN-1:0] WC    = XLEN'(COMPACT_BYTES);
   localparam logic [XLEN-1:0] PF    = XLEN'(PREFETCH);
   localparam logic [XLEN-1:0] D_IRQ = XLEN'(IRQ_VEC) + PF;
   localparam logic [XLEN-1:0] D_SWI = XLEN'(SWI_VEC) + PF;

   p_masked_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !swi_req && stat_in[IDIS_BIT] && !pipe_flush) |=> !entry_we);

   p_swi_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_req && !pipe_flush) |=> (entry_we && mode_tgt == SVC) || (!SWI_WINS && irq_req));

   p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_flush |=> !pipe_flush);

   p_mode_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_we |-> (mode_tgt == SVC || mode_tgt == IRQM) && stat_wdata[4:0] == mode_tgt);

   p_lr_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_we && mode_tgt == IRQM) |->
         lr_wdata == $past(pc_in) - ($past(stat_in[STATE_BIT]) ? WC : WW) + PF);

   p_lr_swi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_we && mode_tgt == SVC) |->
         lr_wdata == $past(pc_in) - ($past(stat_in[STATE_BIT]) ? WC : WW));

   p_pc_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      entry_we |-> pc_wdata == ((mode_tgt == SVC) ? D_SWI : D_IRQ));

   p_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
      entry_we |-> saved_wdata == $past(stat_in));

   p_new_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      entry_we |-> stat_wdata[IDIS_BIT] && !stat_wdata[STATE_BIT]);

   p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (SWI_WINS && swi_req && irq_req && !pipe_flush) |=> mode_tgt == SVC);

   p_lockout_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_flush |=> !entry_we);
endmodule

bind eex_seq eex_seq_chk #(
   .XLEN(XLEN), .STATE_BIT(STATE_BIT), .IDIS_BIT(IDIS_BIT),
   .WIDE_BYTES(WIDE_BYTES), .COMPACT_BYTES(COMPACT_BYTES),
   .PREFETCH(PREFETCH), .IRQ_VEC(IRQ_VEC), .SWI_VEC(SWI_VEC),
   .SWI_WINS(SWI_WINS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
   .stat_in(stat_in), .pc_in(pc_in), .entry_we(entry_we),
   .mode_tgt(mode_tgt), .lr_wdata(lr_wdata), .pc_wdata(pc_wdata),
   .saved_wdata(saved_wdata), .stat_wdata(stat_wdata),
   .pipe_flush(pipe_flush)
);

// File: tb/sim_eex_seq.sv
`timescale 1ns/1ps
module sim_eex_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic        swi_req = 1'b0;
   logic [31:0] stat_in = '0;
   logic [31:0] pc_in = '0;
   logic        entry_we;
   logic [4:0]  mode_tgt;
   logic [31:0] lr_wdata;
   logic [31:0] pc_wdata;
   logic [31:0] saved_wdata;
   logic [31:0] stat_wdata;
   logic        pipe_flush;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [31:0] last_lr = '0;

   always #2.5 clk = ~clk;

   eex_seq u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
      .stat_in(stat_in), .pc_in(pc_in), .entry_we(entry_we),
      .mode_tgt(mode_tgt), .lr_wdata(lr_wdata), .pc_wdata(pc_wdata),
      .saved_wdata(saved_wdata), .stat_wdata(stat_wdata),
      .pipe_flush(pipe_flush)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, {31'd0, entry_we}, 32'd0);
      chk(req, {31'd0, pipe_flush}, 32'd0);
   endtask

   // kind: 0 irq only, 1 swi only, 2 both
   task automatic one_entry(input int kind, input logic st, input logic id,
                            input logic [31:0] pc, input logic [31:0] base);
      logic [31:0] s;
      logic [31:0] w;
      logic [31:0] exp_lr;
      logic [31:0] exp_st;
      logic [4:0]  md;
      logic        swi;
      logic        take;
      s = base;
      s[5] = st;
      s[7] = id;
      swi  = (kind != 0);
      take = swi || !id;
      w  = st ? 32'd2 : 32'd4;
      md = swi ? 5'h13 : 5'h12;
      exp_lr = swi ? pc - w : pc - w + 32'd4;
      exp_st = s;
      exp_st[4:0] = md;
      exp_st[5] = 1'b0;
      exp_st[7] = 1'b1;
      @(negedge clk);
      stat_in = s;
      pc_in   = pc;
      irq_req = (kind != 1);
      swi_req = (kind != 0);
      @(negedge clk);
      irq_req = 1'b0;
      swi_req = 1'b0;
      if (!take) begin
         chk("R2 masked irq no strobe", {31'd0, entry_we}, 32'd0);
         chk("R2 masked irq no flush", {31'd0, pipe_flush}, 32'd0);
         chk("R2 masked irq lr kept", lr_wdata, last_lr);
      end else begin
         chk(swi ? "R3 swi taken" : "R4 irq taken", {31'd0, entry_we}, 32'd1);
         chk("R4 flush", {31'd0, pipe_flush}, 32'd1);
         chk(kind == 2 ? "R11 both -> svc mode" : "R5 mode", {27'd0, mode_tgt}, {27'd0, md});
         chk(swi ? "R7 lr swi" : "R6 lr irq", lr_wdata, exp_lr);
         chk("R8 new pc", pc_wdata, swi ? 32'h0C : 32'h1C);
         chk("R9 saved status", saved_wdata, s);
         chk("R10 new status", stat_wdata, exp_st);
         last_lr = exp_lr;
         @(negedge clk);
         chk_idle("R4 single cycle");
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL R4 watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] pcs [4];
      pcs[0] = 32'h0000_0002;
      pcs[1] = 32'h0800_0100;
      pcs[2] = 32'hFFFF_FFFE;
      pcs[3] = 32'h1234_5678;

      // R1: reset state
      #1;
      chk_idle("R1 in reset");
      chk("R1 lr zero", lr_wdata, 32'd0);
      chk("R1 pc zero", pc_wdata, 32'd0);
      chk("R1 stat zero", stat_wdata, 32'd0);
      chk("R1 saved zero", saved_wdata, 32'd0);
      chk("R1 mode zero", {27'd0, mode_tgt}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after release");
      chk("R1 lr zero after release", lr_wdata, 32'd0);

      for (int k = 0; k < 3; k++)
         for (int st = 0; st < 2; st++)
            for (int id = 0; id < 2; id++)
               for (int p = 0; p < 4; p++)
                  one_entry(k, st[0], id[0], pcs[p],
                            (32'hA000_0010 ^ (32'(p) << 12)) | (32'(k) << 20) | 32'h40);

      // R12: request held through the flush cycle
      @(negedge clk);
      stat_in = 32'h0000_0010;
      pc_in   = 32'h0000_1000;
      swi_req = 1'b1;
      @(negedge clk);
      chk("R12 first entry", {31'd0, pipe_flush}, 32'd1);
      @(negedge clk);
      chk("R12 request ignored during flush", {31'd0, entry_we}, 32'd0);
      @(negedge clk);
      chk("R12 held request taken after flush", {31'd0, entry_we}, 32'd1);
      chk("R12 lr after retake", lr_wdata, 32'h0000_0FFC);
      swi_req = 1'b0;
      @(negedge clk);
      chk_idle("R12 idle again");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule